// File: doc/BRIEF.md
# Torus Dimension-Order Router Node

This block is one node of a two-dimensional torus whose links each carry traffic in a single direction. The X link goes towards X+1 and the Y link towards Y+1, both modulo the ring size. Flits enter from a local injection port, from the incoming X link and from the incoming Y link. They leave on the outgoing X link, on the outgoing Y link, or through the local ejection port. A head flit names its destination. The node closes the whole X distance before it takes any Y step, so a given source and destination always use the same path. No software has to set up routes or schedule traffic.

Each physical link carries two virtual channels, and each has its own input FIFO. A packet travels on channel 0 until it crosses the wraparound link of its current ring, and on channel 1 after that. When it turns from X into Y it goes back to channel 0. This dateline rule breaks the cyclic buffer dependency inside each ring. An output virtual channel stays with one packet from its head flit to its tail flit. A round-robin arbiter resolves contention for it, and a per-channel credit (ready) bit from downstream gates every link transfer.

Top module: `torus_node`

## Requirements
- R1: After reset no output is valid, `inj_ready` is 1, and both bits of `xi_ready` and `yi_ready` are 1.
- R2: A flit is FW = DW+2 bits: bit FW-1 marks a head, bit FW-2 marks a tail (both set for a one-flit packet), and bits DW-1:0 carry data. In a head flit, data bits XW-1:0 hold the destination X and bits XW+YW-1:XW hold the destination Y. A head whose destination X differs from `MY_X` leaves on the X link.
- R3: A head whose destination X equals `MY_X` and whose destination Y differs from `MY_Y` leaves on the Y link.
- R4: A head whose destination equals (`MY_X`, `MY_Y`) leaves through the ejection port.
- R5: Traffic on the X link uses channel 1 (`xo_vc`=1) if the packet arrived on X channel 1, or if this node sits at X = XN-1. Otherwise it uses channel 0. The Y link follows the same rule with Y channel 1 and YN-1. Packets from injection or from the X link therefore start on Y channel 0 unless the node is at Y = YN-1.
- R6: An output virtual channel carries a packet's flits from head to tail with no flit of another packet in between.
- R7: Heads that compete for the same output channel are granted in round-robin order over the five input queues. A queue that has just been served yields to any other waiting queue.
- R8: A link flit is presented only on a channel whose ready bit is 1, and valid itself is the transfer. While `ej_ready` is 0, a valid ejection flit stays valid and unchanged.
- R9: Each input link raises a separate ready bit per virtual channel, and that bit drops to 0 when the channel's DEPTH-entry FIFO is full. The other channel's ready bit is not affected.
- R10: Every flit leaves unchanged, and the flits of one packet leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_valid | input | 1 | Local injection flit valid |
| inj_flit | input | FW | Local injection flit |
| inj_ready | output | 1 | Injection FIFO can accept |
| xi_valid | input | 1 | Incoming X link flit valid |
| xi_vc | input | 1 | Virtual channel of incoming X flit |
| xi_flit | input | FW | Incoming X link flit |
| xi_ready | output | 2 | Per-channel space on incoming X link |
| yi_valid | input | 1 | Incoming Y link flit valid |
| yi_vc | input | 1 | Virtual channel of incoming Y flit |
| yi_flit | input | FW | Incoming Y link flit |
| yi_ready | output | 2 | Per-channel space on incoming Y link |
| xo_valid | output | 1 | Outgoing X flit transferred this cycle |
| xo_vc | output | 1 | Virtual channel of outgoing X flit |
| xo_flit | output | FW | Outgoing X link flit |
| xo_ready | input | 2 | Per-channel space at the downstream X node |
| yo_valid | output | 1 | Outgoing Y flit transferred this cycle |
| yo_vc | output | 1 | Virtual channel of outgoing Y flit |
| yo_flit | output | FW | Outgoing Y link flit |
| yo_ready | input | 2 | Per-channel space at the downstream Y node |
| ej_valid | output | 1 | Ejection flit valid |
| ej_flit | output | FW | Ejection flit |
| ej_ready | input | 1 | Local sink accepts ejection flit |

## Verification
The bound checker watches every cycle for four things. Each output head must match its destination rule (X link, Y link or ejection). Link flits must appear only on a channel whose ready bit is set. A stalled ejection flit must stay stable. Heads and body flits on each output channel must alternate the way an unbroken packet would. On a wrap node it also requires channel 1 on that link. Only the bench scenarios can show the rest: the grant order among competing queues, the return to channel 0 on a turn, per-channel input backpressure, and the exact payload and order of every delivered flit, which the scoreboard compares.

// File: rtl/torus_pkg.sv
package torus_pkg;

    // Output channels of the node: ejection plus two virtual channels per link.
    typedef enum logic [2:0] {
        CH_EJ = 3'd0,
        CH_X0 = 3'd1,
        CH_X1 = 3'd2,
        CH_Y0 = 3'd3,
        CH_Y1 = 3'd4
    } chan_e;

    localparam int NQ      = 5;   // input queues
    localparam int NCH     = 5;   // output channels
    localparam int QIDX_W  = 3;

    // Input queue numbering, also the round-robin order.
    localparam int Q_INJ = 0;
    localparam int Q_XV0 = 1;
    localparam int Q_XV1 = 2;
    localparam int Q_YV0 = 3;
    localparam int Q_YV1 = 4;

    typedef struct packed {
        logic                held;
        logic [QIDX_W-1:0]   owner;
    } chan_state_t;

    function automatic int coord_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [QIDX_W-1:0] oh_to_idx(logic [NQ-1:0] oh);
        logic [QIDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < NQ; i++) begin
            if (oh[i]) r = QIDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/torus_vc_fifo.sv
module torus_vc_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= step(wp);
            if (do_rd) rp <= step(rp);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/torus_rr_arb.sv
module torus_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr, win;
    logic          found;

    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && req[(int'(ptr) + i) % N]) begin
                gnt[(int'(ptr) + i) % N] = 1'b1;
                win   = PW'((int'(ptr) + i) % N);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv && found) begin
            ptr <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
        end
    end
endmodule

// File: rtl/torus_route.sv
module torus_route
    import torus_pkg::*;
#(
    parameter int XN      = 4,
    parameter int YN      = 4,
    parameter int MY_X    = 0,
    parameter int MY_Y    = 0,
    parameter int XW      = 2,
    parameter int YW      = 2,
    parameter bit ON_XVC1 = 1'b0,
    parameter bit ON_YVC1 = 1'b0
) (
    input  logic [XW+YW-1:0] dest,
    output chan_e            ch
);
    localparam bit X_WRAP = (MY_X == XN - 1);
    localparam bit Y_WRAP = (MY_Y == YN - 1);

    logic [XW-1:0] dx;
    logic [YW-1:0] dy;

    assign dx = dest[XW-1:0];
    assign dy = dest[XW+YW-1:XW];

    always_comb begin
        if (dx != XW'(MY_X)) begin
            ch = (ON_XVC1 || X_WRAP) ? CH_X1 : CH_X0;
        end else if (dy != YW'(MY_Y)) begin
            ch = (ON_YVC1 || Y_WRAP) ? CH_Y1 : CH_Y0;
        end else begin
            ch = CH_EJ;
        end
    end
endmodule

// File: rtl/torus_node.sv
module torus_node
    import torus_pkg::*;
#(
    parameter int XN    = 4,
    parameter int YN    = 4,
    parameter int MY_X  = 3,
    parameter int MY_Y  = 2,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inj_valid,
    input  logic [DW+1:0]        inj_flit,
    output logic                 inj_ready,
    input  logic                 xi_valid,
    input  logic                 xi_vc,
    input  logic [DW+1:0]        xi_flit,
    output logic [1:0]           xi_ready,
    input  logic                 yi_valid,
    input  logic                 yi_vc,
    input  logic [DW+1:0]        yi_flit,
    output logic [1:0]           yi_ready,
    output logic                 xo_valid,
    output logic                 xo_vc,
    output logic [DW+1:0]        xo_flit,
    input  logic [1:0]           xo_ready,
    output logic                 yo_valid,
    output logic                 yo_vc,
    output logic [DW+1:0]        yo_flit,
    input  logic [1:0]           yo_ready,
    output logic                 ej_valid,
    output logic [DW+1:0]        ej_flit,
    input  logic                 ej_ready
);
    localparam int XW = coord_w(XN);
    localparam int YW = coord_w(YN);
    localparam int FW = DW + 2;
    localparam int HB = FW - 1;
    localparam int TB = FW - 2;

    // ---------------- input queues ----------------
    logic [NQ-1:0] q_push, q_pop, q_empty, q_full, q_is_head, q_busy;
    logic [FW-1:0] q_din  [NQ];
    logic [FW-1:0] q_head [NQ];
    chan_e         q_route[NQ];

    assign q_din[Q_INJ] = inj_flit;
    assign q_din[Q_XV0] = xi_flit;
    assign q_din[Q_XV1] = xi_flit;
    assign q_din[Q_YV0] = yi_flit;
    assign q_din[Q_YV1] = yi_flit;

    assign inj_ready = !q_full[Q_INJ];
    assign xi_ready  = {!q_full[Q_XV1], !q_full[Q_XV0]};
    assign yi_ready  = {!q_full[Q_YV1], !q_full[Q_YV0]};

    assign q_push[Q_INJ] = inj_valid && inj_ready;
    assign q_push[Q_XV0] = xi_valid && !xi_vc && xi_ready[0];
    assign q_push[Q_XV1] = xi_valid &&  xi_vc && xi_ready[1];
    assign q_push[Q_YV0] = yi_valid && !yi_vc && yi_ready[0];
    assign q_push[Q_YV1] = yi_valid &&  yi_vc && yi_ready[1];

    for (genvar q = 0; q < NQ; q++) begin : g_q
        torus_vc_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[q]),
            .din   (q_din[q]),
            .pop   (q_pop[q]),
            .dout  (q_head[q]),
            .empty (q_empty[q]),
            .full  (q_full[q])
        );

        torus_route #(
            .XN(XN), .YN(YN), .MY_X(MY_X), .MY_Y(MY_Y), .XW(XW), .YW(YW),
            .ON_XVC1(q == Q_XV1), .ON_YVC1(q == Q_YV1)
        ) u_route (
            .dest (q_head[q][XW+YW-1:0]),
            .ch   (q_route[q])
        );

        assign q_is_head[q] = !q_empty[q] && q_head[q][HB];
    end

    // ---------------- output channel allocation ----------------
    chan_state_t   cs        [NCH];
    logic [NQ-1:0] alloc_req [NCH];
    logic [NQ-1:0] alloc_gnt [NCH];
    logic [NCH-1:0] ch_avail, ch_send;
    logic [FW-1:0]  ch_flit [NCH];

    always_comb begin
        q_busy = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int q = 0; q < NQ; q++) begin
                if (cs[c].held && cs[c].owner == QIDX_W'(q)) q_busy[q] = 1'b1;
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            for (int q = 0; q < NQ; q++) begin
                alloc_req[c][q] = q_is_head[q] && (q_route[q] == chan_e'(c))
                                  && !cs[c].held && !q_busy[q];
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        torus_rr_arb #(.N(NQ)) u_alloc (
            .clk (clk),
            .rst (rst),
            .req (alloc_req[c]),
            .adv (!cs[c].held),
            .gnt (alloc_gnt[c])
        );

        assign ch_flit[c]  = q_head[cs[c].owner];
        assign ch_avail[c] = cs[c].held && !q_empty[cs[c].owner];

        always_ff @(posedge clk) begin
            if (rst) begin
                cs[c] <= '0;
            end else if (!cs[c].held && (alloc_gnt[c] != '0)) begin
                cs[c].held  <= 1'b1;
                cs[c].owner <= oh_to_idx(alloc_gnt[c]);
            end else if (ch_send[c] && ch_flit[c][TB]) begin
                cs[c].held  <= 1'b0;
            end
        end
    end

    // ---------------- link switch: one flit per link per cycle ----------------
    logic [1:0]    lk_rdy   [2];
    logic [1:0]    lk_gnt   [2];
    logic          lk_valid [2];
    logic          lk_vc    [2];
    logic [FW-1:0] lk_flit  [2];

    assign lk_rdy[0] = xo_ready;
    assign lk_rdy[1] = yo_ready;

    for (genvar l = 0; l < 2; l++) begin : g_link
        localparam int C0 = 1 + 2 * l;
        localparam int C1 = 2 + 2 * l;
        logic [1:0] vc_req;

        assign vc_req = {ch_avail[C1] && lk_rdy[l][1], ch_avail[C0] && lk_rdy[l][0]};

        torus_rr_arb #(.N(2)) u_vcsel (
            .clk (clk),
            .rst (rst),
            .req (vc_req),
            .adv (1'b1),
            .gnt (lk_gnt[l])
        );

        assign ch_send[C0] = lk_gnt[l][0];
        assign ch_send[C1] = lk_gnt[l][1];
        assign lk_valid[l] = |lk_gnt[l];
        assign lk_vc[l]    = lk_gnt[l][1];
        assign lk_flit[l]  = lk_gnt[l][1] ? ch_flit[C1] : ch_flit[C0];
    end

    assign xo_valid = lk_valid[0];
    assign xo_vc    = lk_vc[0];
    assign xo_flit  = lk_flit[0];
    assign yo_valid = lk_valid[1];
    assign yo_vc    = lk_vc[1];
    assign yo_flit  = lk_flit[1];

    // ---------------- ejection ----------------
    assign ej_valid       = ch_avail[CH_EJ];
    assign ej_flit        = ch_flit[CH_EJ];
    assign ch_send[CH_EJ] = ch_avail[CH_EJ] && ej_ready;

    always_comb begin
        q_pop = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_send[c]) q_pop[cs[c].owner] = 1'b1;
        end
    end
endmodule

// File: rtl/torus_node_chk.sv
module torus_node_chk #(
    parameter int XN   = 4,
    parameter int YN   = 4,
    parameter int MY_X = 3,
    parameter int MY_Y = 2,
    parameter int DW   = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          xo_valid,
    input logic          xo_vc,
    input logic [DW+1:0] xo_flit,
    input logic [1:0]    xo_ready,
    input logic          yo_valid,
    input logic          yo_vc,
    input logic [DW+1:0] yo_flit,
    input logic [1:0]    yo_ready,
    input logic          ej_valid,
    input logic [DW+1:0] ej_flit,
    input logic          ej_ready
);
    localparam int XW = (XN > 1) ? $clog2(XN) : 1;
    localparam int YW = (YN > 1) ? $clog2(YN) : 1;
    localparam int HB = DW + 1;
    localparam int TB = DW;

    logic [1:0] open_x, open_y;
    logic       open_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_x <= '0;
            open_y <= '0;
            open_e <= 1'b0;
        end else begin
            if (xo_valid) open_x[xo_vc] <= !xo_flit[TB];
            if (yo_valid) open_y[yo_vc] <= !yo_flit[TB];
            if (ej_valid && ej_ready) open_e <= !ej_flit[TB];
        end
    end

    a_r2_x_dest: assert property (@(posedge clk) disable iff (rst)
        xo_valid && xo_flit[HB] |-> xo_flit[XW-1:0] != XW'(MY_X));

    a_r3_y_dest: assert property (@(posedge clk) disable iff (rst)
        yo_valid && yo_flit[HB] |->
            (yo_flit[XW-1:0] == XW'(MY_X)) && (yo_flit[XW+YW-1:XW] != YW'(MY_Y)));

    a_r4_ej_dest: assert property (@(posedge clk) disable iff (rst)
        ej_valid && ej_flit[HB] |->
            (ej_flit[XW-1:0] == XW'(MY_X)) && (ej_flit[XW+YW-1:XW] == YW'(MY_Y)));

    a_r5_x_wrap: assert property (@(posedge clk) disable iff (rst)
        xo_valid && (MY_X == XN - 1) |-> xo_vc);

    a_r5_y_wrap: assert property (@(posedge clk) disable iff (rst)
        yo_valid && (MY_Y == YN - 1) |-> yo_vc);

    a_r6_x_whole: assert property (@(posedge clk) disable iff (rst)
        xo_valid |-> (xo_flit[HB] == !open_x[xo_vc]));

    a_r6_y_whole: assert property (@(posedge clk) disable iff (rst)
        yo_valid |-> (yo_flit[HB] == !open_y[yo_vc]));

    a_r6_ej_whole: assert property (@(posedge clk) disable iff (rst)
        ej_valid && ej_ready |-> (ej_flit[HB] == !open_e));

    a_r8_x_credit: assert property (@(posedge clk) disable iff (rst)
        xo_valid |-> xo_ready[xo_vc]);

    a_r8_y_credit: assert property (@(posedge clk) disable iff (rst)
        yo_valid |-> yo_ready[yo_vc]);

    a_r8_ej_hold: assert property (@(posedge clk) disable iff (rst)
        ej_valid && !ej_ready |=> ej_valid && $stable(ej_flit));

    a_r10_x_known: assert property (@(posedge clk) disable iff (rst)
        xo_valid |-> !$isunknown(xo_flit));

    a_r10_y_known: assert property (@(posedge clk) disable iff (rst)
        yo_valid |-> !$isunknown(yo_flit));
endmodule

bind torus_node torus_node_chk #(
    .XN(XN), .YN(YN), .MY_X(MY_X), .MY_Y(MY_Y), .DW(DW)
) u_chk (.*);

// File: tb/sim_torus_node.sv
module sim_torus_node;
    localparam int DW = 16;
    localparam int FW = DW + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          inj_valid = 1'b0;
    logic [FW-1:0] inj_flit  = '0;
    logic          inj_ready;
    logic          xi_valid = 1'b0;
    logic          xi_vc    = 1'b0;
    logic [FW-1:0] xi_flit  = '0;
    logic [1:0]    xi_ready;
    logic          yi_valid = 1'b0;
    logic          yi_vc    = 1'b0;
    logic [FW-1:0] yi_flit  = '0;
    logic [1:0]    yi_ready;
    logic          xo_valid, xo_vc;
    logic [FW-1:0] xo_flit;
    logic [1:0]    xo_ready = 2'b11;
    logic          yo_valid, yo_vc;
    logic [FW-1:0] yo_flit;
    logic [1:0]    yo_ready = 2'b11;
    logic          ej_valid;
    logic [FW-1:0] ej_flit;
    logic          ej_ready = 1'b1;

    always #2 clk = ~clk;

    torus_node u0 (.*);

    int total = 0;
    int bad   = 0;

    logic [FW:0]   exp_x[$];
    logic [FW:0]   exp_y[$];
    logic [FW-1:0] exp_e[$];

    function automatic logic [FW-1:0] mk(bit h, bit t, int dx, int dy, int tag);
        return {h, t, 12'(tag), 2'(dy), 2'(dx)};
    endfunction

    task automatic check(bit ok, string req, string what, logic [FW:0] act, logic [FW:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (!rst) begin
            if (xo_valid) begin
                if (exp_x.size() == 0) check(1'b0, "R2", "unexpected X flit", {xo_vc, xo_flit}, '0);
                else begin
                    logic [FW:0] e;
                    e = exp_x.pop_front();
                    check({xo_vc, xo_flit} == e, "R2/R5/R10", "X link flit", {xo_vc, xo_flit}, e);
                end
            end
            if (yo_valid) begin
                if (exp_y.size() == 0) check(1'b0, "R3", "unexpected Y flit", {yo_vc, yo_flit}, '0);
                else begin
                    logic [FW:0] e;
                    e = exp_y.pop_front();
                    check({yo_vc, yo_flit} == e, "R3/R5/R10", "Y link flit", {yo_vc, yo_flit}, e);
                end
            end
            if (ej_valid && ej_ready) begin
                if (exp_e.size() == 0) check(1'b0, "R4", "unexpected eject flit", {1'b0, ej_flit}, '0);
                else begin
                    logic [FW-1:0] e;
                    e = exp_e.pop_front();
                    check(ej_flit == e, "R4/R7/R10", "eject flit", {1'b0, ej_flit}, {1'b0, e});
                end
            end
        end
    end

    // ---------------- drivers ----------------
    task automatic mid();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_inj(logic [FW-1:0] f);
        @(negedge clk);
        inj_valid = 1'b1;
        inj_flit  = f;
        while (!inj_ready) @(negedge clk);
        @(negedge clk);
        inj_valid = 1'b0;
    endtask

    task automatic drive_x(bit vc, logic [FW-1:0] f);
        @(negedge clk);
        xi_valid = 1'b1;
        xi_vc    = vc;
        xi_flit  = f;
        while (!xi_ready[vc]) @(negedge clk);
        @(negedge clk);
        xi_valid = 1'b0;
    endtask

    task automatic drive_y(bit vc, logic [FW-1:0] f);
        @(negedge clk);
        yi_valid = 1'b1;
        yi_vc    = vc;
        yi_flit  = f;
        while (!yi_ready[vc]) @(negedge clk);
        @(negedge clk);
        yi_valid = 1'b0;
    endtask

    task automatic inj_pkt(int dx, int dy, int len, int tag);
        for (int i = 0; i < len; i++) drive_inj(mk(i == 0, i == len - 1, dx, dy, tag + i));
    endtask

    task automatic xi_pkt(bit vc, int dx, int dy, int len, int tag);
        for (int i = 0; i < len; i++) drive_x(vc, mk(i == 0, i == len - 1, dx, dy, tag + i));
    endtask

    task automatic yi_pkt(bit vc, int dx, int dy, int len, int tag);
        for (int i = 0; i < len; i++) drive_y(vc, mk(i == 0, i == len - 1, dx, dy, tag + i));
    endtask

    // where: 0 = X link, 1 = Y link, 2 = eject
    task automatic exp_pkt(int where, bit vc, int dx, int dy, int len, int tag);
        for (int i = 0; i < len; i++) begin
            logic [FW-1:0] f;
            f = mk(i == 0, i == len - 1, dx, dy, tag + i);
            if (where == 0)      exp_x.push_back({vc, f});
            else if (where == 1) exp_y.push_back({vc, f});
            else                 exp_e.push_back(f);
        end
    endtask

    task automatic wait_drain(string req);
        int n;
        n = 0;
        while ((exp_x.size() + exp_y.size() + exp_e.size()) != 0 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n < 1000, req, "all expected flits delivered", FW'(exp_x.size() + exp_y.size() + exp_e.size()), '0);
        repeat (4) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #600000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [FW-1:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(!xo_valid, "R1", "xo_valid after reset", {18'b0, xo_valid}, '0);
        check(!yo_valid, "R1", "yo_valid after reset", {18'b0, yo_valid}, '0);
        check(!ej_valid, "R1", "ej_valid after reset", {18'b0, ej_valid}, '0);
        check(inj_ready, "R1", "inj_ready after reset", {18'b0, inj_ready}, 1);
        check(xi_ready == 2'b11, "R1", "xi_ready after reset", {17'b0, xi_ready}, 3);
        check(yi_ready == 2'b11, "R1", "yi_ready after reset", {17'b0, yi_ready}, 3);

        // R7: injection owns eject first; its second packet then waits behind the X-link packet
        mid();
        ej_ready = 1'b0;
        exp_pkt(2, 0, 3, 2, 2, 16'h100);
        exp_pkt(2, 0, 3, 2, 2, 16'h300);
        exp_pkt(2, 0, 3, 2, 2, 16'h200);
        fork
            begin inj_pkt(3, 2, 2, 16'h100); inj_pkt(3, 2, 2, 16'h200); end
            xi_pkt(1'b0, 3, 2, 2, 16'h300);
        join
        repeat (3) @(negedge clk);
        mid();
        ej_ready = 1'b1;
        wait_drain("R7");

        // R6: two packets contend for X channel 1, each leaves whole
        mid();
        xo_ready = 2'b00;
        exp_pkt(0, 1, 1, 0, 3, 16'h400);
        exp_pkt(0, 1, 2, 1, 3, 16'h500);
        fork
            inj_pkt(1, 0, 3, 16'h400);
            xi_pkt(1'b1, 2, 1, 3, 16'h500);
        join
        repeat (3) @(negedge clk);
        mid();
        xo_ready = 2'b11;
        wait_drain("R6");

        // R2: X differs -> X link, wrap node uses channel 1
        exp_pkt(0, 1, 0, 2, 1, 16'h600);
        inj_pkt(0, 2, 1, 16'h600);
        wait_drain("R2");

        // R3: X matches, Y differs -> Y link, channel 0
        exp_pkt(1, 0, 3, 0, 3, 16'h700);
        inj_pkt(3, 0, 3, 16'h700);
        wait_drain("R3");

        // R4: own coordinate -> eject
        exp_pkt(2, 0, 3, 2, 2, 16'h800);
        inj_pkt(3, 2, 2, 16'h800);
        wait_drain("R4");

        // R5: turning from X channel 1 into Y restarts on channel 0
        exp_pkt(1, 0, 3, 1, 2, 16'h900);
        xi_pkt(1'b1, 3, 1, 2, 16'h900);
        wait_drain("R5");
        // R5: X channel 0 arrival crossing the wrap here moves to channel 1
        exp_pkt(0, 1, 1, 2, 2, 16'hA00);
        xi_pkt(1'b0, 1, 2, 2, 16'hA00);
        wait_drain("R5");
        // R5: Y channel kept while continuing in Y
        exp_pkt(1, 1, 3, 0, 2, 16'hB00);
        yi_pkt(1'b1, 3, 0, 2, 16'hB00);
        wait_drain("R5");
        exp_pkt(1, 0, 3, 3, 2, 16'hC00);
        yi_pkt(1'b0, 3, 3, 2, 16'hC00);
        wait_drain("R5");

        // R8: no Y flit while its channel has no credit
        mid();
        yo_ready = 2'b00;
        exp_pkt(1, 0, 3, 0, 1, 16'hD00);
        inj_pkt(3, 0, 1, 16'hD00);
        repeat (6) @(negedge clk);
        check(!yo_valid, "R8", "Y held without credit", {18'b0, yo_valid}, '0);
        mid();
        yo_ready = 2'b10;
        repeat (4) @(negedge clk);
        check(!yo_valid, "R8", "Y held with only other channel ready", {18'b0, yo_valid}, '0);
        mid();
        yo_ready = 2'b11;
        wait_drain("R8");

        // R8: eject flit stays while sink stalls
        mid();
        ej_ready = 1'b0;
        exp_pkt(2, 0, 3, 2, 1, 16'hE00);
        inj_pkt(3, 2, 1, 16'hE00);
        repeat (3) @(negedge clk);
        check(ej_valid, "R8", "eject valid while stalled", {18'b0, ej_valid}, 1);
        check(ej_flit == mk(1, 1, 3, 2, 16'hE00), "R8", "eject flit while stalled",
              {1'b0, ej_flit}, {1'b0, mk(1, 1, 3, 2, 16'hE00)});
        held = ej_flit;
        repeat (2) @(negedge clk);
        check(ej_valid && ej_flit == held, "R8", "eject flit stable", {ej_valid, ej_flit}, {1'b1, held});
        mid();
        ej_ready = 1'b1;
        wait_drain("R8");

        // R9: filling Y channel 0 drops only its ready bit
        mid();
        yo_ready = 2'b00;
        exp_pkt(1, 0, 3, 3, 4, 16'hF00);
        yi_pkt(1'b0, 3, 3, 4, 16'hF00);
        repeat (2) @(negedge clk);
        check(yi_ready == 2'b10, "R9", "yi_ready with channel 0 full", {17'b0, yi_ready}, 2);
        mid();
        yo_ready = 2'b11;
        wait_drain("R9");
        check(yi_ready == 2'b11, "R9", "yi_ready after drain", {17'b0, yi_ready}, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule